// File: doc/BRIEF.md
# Reclocker Output Path Selector

This block sits at the output of a serial reclocker. It takes four serial data lanes and picks one of them with a two-bit select. The picked lane then reaches the output in one of two ways. On the retimed path it goes through a flop clocked by the retime clock. On the bypass path it goes through combinational logic, straight from the input.

A small state machine, clocked by the retime clock, decides which path drives the output. It reads three controls and the lock indication:
- a forced-bypass request;
- an automatic bypass on loss of lock;
- an active-low mute.

Forced bypass has priority over automatic bypass. Automatic bypass acts only while lock is low. Mute acts only while the block is reclocking. A status output reports when either bypass path is active.

The state machine has four states:
- `ST_RETIME`: the output is the retimed flop.
- `ST_MUTE`: the output is held at constant 0.
- `ST_BYP_FORCE`: the output is the raw selected lane, because of a forced request.
- `ST_BYP_AUTO`: the output is the raw selected lane, because lock is lost and automatic bypass is enabled.

Every state can reach every other state at each retime clock edge. The next state is chosen in a fixed priority order:
1. `TR_FORCE` is taken when forced bypass is high.
2. `TR_AUTO` is taken when automatic bypass is high and lock is low.
3. `TR_MUTE` is taken when mute is low.
4. `TR_RETIME` is taken otherwise.

Top module: `rc_bypass_mute_sel`

## Requirements
- R1: Select value 0, 1, 2 or 3 (binary 00, 01, 10, 11) routes lane 0, 1, 2 or 3 respectively to the output path.
- R2: While forced bypass is high at a retime edge, from that edge on the output follows the currently selected raw lane combinationally, and `bypass_active` is 1.
- R3: Automatic bypass puts the block into bypass only when lock is low. With lock high and forced bypass low, automatic bypass has no effect and the output is retimed.
- R4: Forced bypass takes precedence over automatic bypass and over lock: with forced bypass high, the block is in bypass whatever the values of automatic bypass and lock.
- R5: When neither bypass condition holds and mute is low at a retime edge, the output is constant 0 after that edge and `bypass_active` is 0.
- R6: In either bypass state, mute has no effect: the output still follows the raw selected lane.
- R7: When neither bypass condition holds and mute is high, the output equals the selected lane as sampled at the previous retime edge. This also applies when lock is low and both bypass controls are low (the data is then not guaranteed meaningful).
- R8: A change of the path controls takes effect only at the next retime clock edge. Between edges, the output and `bypass_active` keep the previous path.
- R9: While reset is low, the state is `ST_RETIME` and the retime flop holds 0, so the output is 0 and `bypass_active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Retime clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | N_IN (4) | Serial input lanes, bit i is lane i |
| in_sel | input | SEL_W (2) | Lane select |
| force_byp | input | 1 | Forced bypass request, active high |
| auto_byp | input | 1 | Bypass-on-unlock enable, active high |
| pll_lock | input | 1 | Lock indication, high when locked |
| mute_n | input | 1 | Output mute, active low |
| ser_out | output | 1 | Serial output |
| bypass_active | output | 1 | High while a bypass state drives the output |

## Verification
The case hardest to reach from the ports is telling the two paths apart. They carry the same bit whenever the lane is steady across an edge. To separate them, the stimulus sets one lane pattern before a retime edge and a different pattern just after it. A bypass path then shows the new bit, while the retimed path still shows the bit captured at the edge.

The second hard case is the window between a control change and the next edge. The bench changes forced bypass between edges and samples the outputs before the edge, to show that the path has not moved yet.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        ST_RETIME    = 2'b00,
        ST_MUTE      = 2'b01,
        ST_BYP_FORCE = 2'b10,
        ST_BYP_AUTO  = 2'b11
    } rc_path_e;

    function automatic logic path_is_bypass(input rc_path_e p);
        return (p == ST_BYP_FORCE) || (p == ST_BYP_AUTO);
    endfunction

endpackage

// File: rtl/rc_input_mux.sv
module rc_input_mux #(
    parameter int N_IN = 4,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]  lanes,
    input  logic [SEL_W-1:0] sel,
    output logic             picked
);
    logic [N_IN-1:0] hit;

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        assign hit[g] = lanes[g] & (sel == SEL_W'(g));
    end

    assign picked = |hit;
endmodule

// File: rtl/rc_retime_reg.sv
module rc_retime_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/rc_path_fsm.sv
module rc_path_fsm
    import rc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     force_byp,
    input  logic     auto_byp,
    input  logic     pll_lock,
    input  logic     mute_n,
    output rc_path_e state
);
    rc_path_e nxt;

    always_comb begin
        if (force_byp)                  nxt = ST_BYP_FORCE;
        else if (auto_byp && !pll_lock) nxt = ST_BYP_AUTO;
        else if (!mute_n)               nxt = ST_MUTE;
        else                            nxt = ST_RETIME;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RETIME;
        else        state <= nxt;
    end
endmodule

// File: rtl/rc_bypass_mute_sel.sv
module rc_bypass_mute_sel
    import rc_pkg::*;
#(
    parameter int N_IN = 4,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  ser_in,
    input  logic [SEL_W-1:0] in_sel,
    input  logic             force_byp,
    input  logic             auto_byp,
    input  logic             pll_lock,
    input  logic             mute_n,
    output logic             ser_out,
    output logic             bypass_active
);
    logic     raw_bit;
    logic     retimed_bit;
    rc_path_e state;

    rc_input_mux #(.N_IN(N_IN)) u_mux (
        .lanes  (ser_in),
        .sel    (in_sel),
        .picked (raw_bit)
    );

    rc_retime_reg u_rt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bit),
        .q     (retimed_bit)
    );

    rc_path_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_byp (force_byp),
        .auto_byp  (auto_byp),
        .pll_lock  (pll_lock),
        .mute_n    (mute_n),
        .state     (state)
    );

    always_comb begin
        unique case (state)
            ST_RETIME:    ser_out = retimed_bit;
            ST_MUTE:      ser_out = 1'b0;
            ST_BYP_FORCE: ser_out = raw_bit;
            ST_BYP_AUTO:  ser_out = raw_bit;
            default:      ser_out = 1'b0;
        endcase
    end

    assign bypass_active = path_is_bypass(state);
endmodule

// File: rtl/rc_bypass_mute_sel_chk.sv
module rc_bypass_mute_sel_chk #(
    parameter int N_IN = 4,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  ser_in,
    input logic [SEL_W-1:0] in_sel,
    input logic             force_byp,
    input logic             auto_byp,
    input logic             pll_lock,
    input logic             mute_n,
    input logic             ser_out,
    input logic             bypass_active
);
    logic sel_bit;
    logic no_byp;
    assign sel_bit = ser_in[in_sel];
    assign no_byp  = !force_byp && !(auto_byp && !pll_lock);

    AST_FORCE_BYP: assert property (@(posedge clk) disable iff (!rst_n)
        force_byp |=> bypass_active); // R2
    AST_AUTO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_byp && !pll_lock) |=> bypass_active); // R3
    AST_AUTO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_byp && pll_lock) |=> !bypass_active); // R3
    AST_FORCE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (force_byp && auto_byp && pll_lock) |=> bypass_active); // R4
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (no_byp && !mute_n) |=> (ser_out == 1'b0)); // R5
    AST_BYP_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_active |-> (ser_out == sel_bit)); // R6
    AST_RETIME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (no_byp && mute_n) |=> (ser_out == $past(sel_bit))); // R7
endmodule

bind rc_bypass_mute_sel rc_bypass_mute_sel_chk #(.N_IN(N_IN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_in        (ser_in),
    .in_sel        (in_sel),
    .force_byp     (force_byp),
    .auto_byp      (auto_byp),
    .pll_lock      (pll_lock),
    .mute_n        (mute_n),
    .ser_out       (ser_out),
    .bypass_active (bypass_active)
);

// File: tb/rc_bypass_mute_sel_tb.sv
`timescale 1ns/100ps
module rc_bypass_mute_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ser_in = '0;
    logic [1:0] in_sel = '0;
    logic       force_byp = 1'b0;
    logic       auto_byp = 1'b0;
    logic       pll_lock = 1'b1;
    logic       mute_n = 1'b1;
    logic       ser_out;
    logic       bypass_active;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rc_bypass_mute_sel dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .in_sel(in_sel),
        .force_byp(force_byp), .auto_byp(auto_byp), .pll_lock(pll_lock),
        .mute_n(mute_n), .ser_out(ser_out), .bypass_active(bypass_active)
    );

    // {force, auto, lock, mute_n, sel[1:0], lanes_before_edge[3:0], lanes_after_edge[3:0], exp_out, exp_byp}
    localparam int NV = 14;
    localparam logic [15:0] VEC [NV] = '{
        {4'b0011, 2'd0, 4'b0001, 4'b1110, 2'b10},
        {4'b0011, 2'd1, 4'b0010, 4'b1101, 2'b10},
        {4'b0011, 2'd2, 4'b0100, 4'b1011, 2'b10},
        {4'b0011, 2'd3, 4'b1000, 4'b0111, 2'b10},
        {4'b1011, 2'd2, 4'b0000, 4'b0100, 2'b11},
        {4'b1001, 2'd1, 4'b1111, 4'b0000, 2'b01},
        {4'b0101, 2'd3, 4'b0000, 4'b1000, 2'b11},
        {4'b0111, 2'd3, 4'b1000, 4'b0000, 2'b10},
        {4'b1111, 2'd0, 4'b0000, 4'b0001, 2'b11},
        {4'b0010, 2'd0, 4'b1111, 4'b1111, 2'b00},
        {4'b1010, 2'd1, 4'b0000, 4'b0010, 2'b11},
        {4'b0100, 2'd2, 4'b0000, 4'b0100, 2'b11},
        {4'b0001, 2'd1, 4'b0010, 4'b0000, 2'b10},
        {4'b0000, 2'd0, 4'b1111, 4'b0000, 2'b00}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 2, 3: return "R1";
            4, 5:       return "R2";
            6, 7:       return "R3";
            8:          return "R4";
            9, 13:      return "R5";
            10, 11:     return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic act_o, input logic exp_o,
                         input logic act_b, input logic exp_b);
        tests++;
        if (act_o !== exp_o || act_b !== exp_b) begin
            fails++;
            $display("FAIL %s: ser_out=%b bypass_active=%b expected ser_out=%b bypass_active=%b",
                     req, act_o, act_b, exp_o, exp_b);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        // R9: reset state with lanes all high and controls on the retime path
        ser_in = 4'b1111;
        repeat (3) @(posedge clk);
        #0.5;
        check("R9", ser_out, 1'b0, bypass_active, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {force_byp, auto_byp, pll_lock, mute_n} = VEC[i][15:12];
            in_sel = VEC[i][11:10];
            ser_in = VEC[i][9:6];
            @(posedge clk);
            #0.5;
            ser_in = VEC[i][5:2];
            #0.5;
            check(vec_req(i), ser_out, VEC[i][1], bypass_active, VEC[i][0]);
        end

        // R8: forced bypass raised between edges does not act before the next edge
        @(negedge clk);
        {force_byp, auto_byp, pll_lock, mute_n} = 4'b0011;
        in_sel = 2'd1;
        ser_in = 4'b0010;
        @(posedge clk);
        #0.5;
        ser_in = 4'b0000;
        force_byp = 1'b1;
        #0.5;
        check("R8", ser_out, 1'b1, bypass_active, 1'b0);
        @(posedge clk);
        #0.5;
        check("R8", ser_out, 1'b0, bypass_active, 1'b1);

        // R8: mute dropped between edges keeps the retimed bit until the edge
        @(negedge clk);
        force_byp = 1'b0;
        ser_in = 4'b0010;
        @(posedge clk);
        #0.5;
        mute_n = 1'b0;
        #0.5;
        check("R8", ser_out, 1'b1, bypass_active, 1'b0);
        @(posedge clk);
        #0.5;
        check("R5", ser_out, 1'b0, bypass_active, 1'b0);

        // R9: reset applied mid-run from a bypass state
        @(negedge clk);
        mute_n = 1'b1;
        force_byp = 1'b1;
        ser_in = 4'b1111;
        @(posedge clk);
        #0.5;
        check("R2", ser_out, 1'b1, bypass_active, 1'b1);
        force_byp = 1'b0;
        rst_n = 1'b0;
        #0.5;
        check("R9", ser_out, 1'b0, bypass_active, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule